// File: doc/BRIEF.md
# Interrupt Source Controller

This block keeps the per-source state of a small bank of interrupt sources and offers their interrupts, one at a time, to a single presenter. Each source holds a target server number, a current priority, a saved priority and three flags: asserted, resend and masked-pending. Devices drive level set and clear events. Configuration writes change a source's server and priority, switch it off or switch it back on. The presenter answers every offer with accept or reject. It can also bounce back a source it had accepted earlier, signal end-of-interrupt, and ask for a resend sweep.

No interrupt is lost. An attempt that meets a masked source is remembered as masked-pending. A refused offer is remembered as resend. Unmasking replays either of them. A level source that is still asserted at end-of-interrupt is offered again. Pending work is recorded per source as an attempt request. A round-robin scan serves these requests, and only one offer is outstanding at a time. The priority value with all bits set (0xFF for 8 bits) means masked.

Top module: `intr_src_ctrl`

## Requirements
- R1: After reset every source has current and saved priority 0xFF (masked), no offer is outstanding (`dlv_vld_o`=0) and `resend_req_o`=0; a level set on an unconfigured source produces no offer.
- R2: A level event with `lvl_set_i`=1 marks the source asserted and requests a delivery attempt; with `lvl_set_i`=0 it clears asserted and requests nothing.
- R3: A delivery attempt on a source whose current priority is 0xFF sets its masked-pending flag and issues no offer.
- R4: A configuration write with `cfg_op_i`=0 stores server and priority and copies the priority into the saved priority; if masked-pending or resend is set and the new priority is not 0xFF, masked-pending is cleared and an attempt is requested.
- R5: `cfg_op_i`=1 (off) copies the current priority into the saved priority and sets the current priority to 0xFF; `cfg_op_i`=2 (on) restores the saved priority and replays under the rule of R4; `cfg_op_i`=3 has no effect.
- R6: Every attempt clears the source's resend flag; a reject (`rsp_acc_i`=0) sets it and raises `resend_req_o` one cycle later, which stays high until a cycle with `sweep_i` and no reject.
- R7: On `sweep_i` every source with resend set requests a new attempt.
- R8: An end-of-interrupt for an asserted source requests a new attempt; for a source that is not asserted it does nothing.
- R9: A source number bounced by the presenter is treated as a fresh delivery attempt.
- R10: At most one offer is outstanding; `dlv_vld_o`, `dlv_src_o`, `dlv_prio_o` and `dlv_server_o` hold until the cycle with `rsp_vld_i`, after which `dlv_vld_o` drops; attempts are picked round-robin starting after the last picked source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_vld_i | input | 1 | Level event valid |
| lvl_src_i | input | SW | Source of level event |
| lvl_set_i | input | 1 | 1 = set asserted, 0 = clear |
| cfg_vld_i | input | 1 | Configuration write valid |
| cfg_op_i | input | 2 | 0 write, 1 off, 2 on, 3 none |
| cfg_src_i | input | SW | Source being configured |
| cfg_server_i | input | SRV_W | New server number |
| cfg_prio_i | input | PRIO_W | New priority |
| eoi_vld_i | input | 1 | End-of-interrupt valid |
| eoi_src_i | input | SW | Source of end-of-interrupt |
| bounce_vld_i | input | 1 | Presenter bounces a source |
| bounce_src_i | input | SW | Bounced source |
| sweep_i | input | 1 | Resend sweep request |
| dlv_vld_o | output | 1 | Offer outstanding |
| dlv_src_o | output | SW | Offered source |
| dlv_prio_o | output | PRIO_W | Offered priority |
| dlv_server_o | output | SRV_W | Target server |
| rsp_vld_i | input | 1 | Presenter response valid |
| rsp_acc_i | input | 1 | 1 accept, 0 reject |
| resend_req_o | output | 1 | Resend sweep wanted |

## Verification
The assertions assume that the presenter answers only while an offer is outstanding, and only once per offer. The bench presenter answers a fixed number of cycles after it sees `dlv_vld_o` and never otherwise. Event inputs from devices and software may arrive in any combination in the same cycle, including several on one source. The random phase exercises this on purpose, and the reference model applies the same fixed order within a cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    CFG_WRITE = 2'd0,
    CFG_OFF   = 2'd1,
    CFG_ON    = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell #(
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              rej_i,
  input  logic              lvl_set_i,
  input  logic              lvl_clr_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_off_i,
  input  logic              cfg_on_i,
  input  logic              eoi_i,
  input  logic              bounce_i,
  input  logic              sweep_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  output logic              want_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [SRV_W-1:0]  server_o
);
  localparam logic [PRIO_W-1:0] MASK = '1;

  logic [PRIO_W-1:0] prio_q, prio_d, saved_q, saved_d;
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic asrt_q, asrt_d, rs_q, rs_d, mp_q, mp_d, want_q, want_d;

  // fixed order within a cycle: attempt, response, events
  always_comb begin
    prio_d  = prio_q;
    saved_d = saved_q;
    srv_d   = srv_q;
    asrt_d  = asrt_q;
    rs_d    = rs_q;
    mp_d    = mp_q;
    want_d  = want_q;
    if (issue_i) begin
      want_d = 1'b0;
      rs_d   = 1'b0;
      if (prio_q == MASK) mp_d = 1'b1;
    end
    if (rej_i) rs_d = 1'b1;
    if (lvl_set_i) begin
      asrt_d = 1'b1;
      want_d = 1'b1;
    end
    if (lvl_clr_i) asrt_d = 1'b0;
    if (cfg_wr_i) begin
      srv_d   = cfg_server_i;
      prio_d  = cfg_prio_i;
      saved_d = cfg_prio_i;
      if ((mp_d || rs_d) && cfg_prio_i != MASK) begin
        mp_d   = 1'b0;
        want_d = 1'b1;
      end
    end
    if (cfg_off_i) begin
      saved_d = prio_d;
      prio_d  = MASK;
    end
    if (cfg_on_i) begin
      prio_d = saved_d;
      if ((mp_d || rs_d) && saved_d != MASK) begin
        mp_d   = 1'b0;
        want_d = 1'b1;
      end
    end
    if (eoi_i && asrt_d) want_d = 1'b1;
    if (bounce_i)        want_d = 1'b1;
    if (sweep_i && rs_d) want_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= MASK;
      saved_q <= MASK;
      srv_q   <= '0;
      asrt_q  <= 1'b0;
      rs_q    <= 1'b0;
      mp_q    <= 1'b0;
      want_q  <= 1'b0;
    end else begin
      prio_q  <= prio_d;
      saved_q <= saved_d;
      srv_q   <= srv_d;
      asrt_q  <= asrt_d;
      rs_q    <= rs_d;
      mp_q    <= mp_d;
      want_q  <= want_d;
    end
  end

  assign want_o   = want_q;
  assign prio_o   = prio_q;
  assign server_o = srv_q;
endmodule

// File: rtl/isc_rr_pick.sv
module isc_rr_pick #(
  parameter int N  = 16,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [SW-1:0] ptr_i,
  output logic          any_o,
  output logic [SW-1:0] idx_o
);
  // N must be a power of two: index arithmetic wraps in SW bits
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [SW-1:0] j;
      j = ptr_i + SW'(k);
      if (req_i[j]) begin
        any_o = 1'b1;
        idx_o = j;
      end
    end
  end
endmodule

// File: rtl/intr_src_ctrl.sv
module intr_src_ctrl #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4,
  localparam int SW    = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_vld_i,
  input  logic [SW-1:0]     lvl_src_i,
  input  logic              lvl_set_i,
  input  logic              cfg_vld_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [SW-1:0]     cfg_src_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              eoi_vld_i,
  input  logic [SW-1:0]     eoi_src_i,
  input  logic              bounce_vld_i,
  input  logic [SW-1:0]     bounce_src_i,
  input  logic              sweep_i,
  output logic              dlv_vld_o,
  output logic [SW-1:0]     dlv_src_o,
  output logic [PRIO_W-1:0] dlv_prio_o,
  output logic [SRV_W-1:0]  dlv_server_o,
  input  logic              rsp_vld_i,
  input  logic              rsp_acc_i,
  output logic              resend_req_o
);
  import isc_pkg::*;
  localparam logic [PRIO_W-1:0] MASK = '1;

  logic [NSRC-1:0]   want;
  logic [PRIO_W-1:0] prio_arr [NSRC];
  logic [SRV_W-1:0]  srv_arr  [NSRC];
  logic [SW-1:0]     ptr_q, pick_idx;
  logic              pick_any, issue_en, reject;

  cfg_op_e op;
  assign op       = cfg_op_e'(cfg_op_i);
  assign issue_en = !dlv_vld_o && pick_any;
  assign reject   = dlv_vld_o && rsp_vld_i && !rsp_acc_i;

  isc_rr_pick #(.N(NSRC)) i_pick (
    .req_i (want),
    .ptr_i (ptr_q),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit_cfg;
    assign hit_cfg = cfg_vld_i && cfg_src_i == SW'(g);
    isc_src_cell #(.PRIO_W(PRIO_W), .SRV_W(SRV_W)) i_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .issue_i      (issue_en && pick_idx == SW'(g)),
      .rej_i        (reject && dlv_src_o == SW'(g)),
      .lvl_set_i    (lvl_vld_i && lvl_set_i && lvl_src_i == SW'(g)),
      .lvl_clr_i    (lvl_vld_i && !lvl_set_i && lvl_src_i == SW'(g)),
      .cfg_wr_i     (hit_cfg && op == CFG_WRITE),
      .cfg_off_i    (hit_cfg && op == CFG_OFF),
      .cfg_on_i     (hit_cfg && op == CFG_ON),
      .eoi_i        (eoi_vld_i && eoi_src_i == SW'(g)),
      .bounce_i     (bounce_vld_i && bounce_src_i == SW'(g)),
      .sweep_i      (sweep_i),
      .cfg_server_i (cfg_server_i),
      .cfg_prio_i   (cfg_prio_i),
      .want_o       (want[g]),
      .prio_o       (prio_arr[g]),
      .server_o     (srv_arr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      dlv_vld_o    <= 1'b0;
      dlv_src_o    <= '0;
      dlv_prio_o   <= '0;
      dlv_server_o <= '0;
    end else if (issue_en) begin
      ptr_q <= pick_idx + SW'(1);
      if (prio_arr[pick_idx] != MASK) begin
        dlv_vld_o    <= 1'b1;
        dlv_src_o    <= pick_idx;
        dlv_prio_o   <= prio_arr[pick_idx];
        dlv_server_o <= srv_arr[pick_idx];
      end
    end else if (dlv_vld_o && rsp_vld_i) begin
      dlv_vld_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      resend_req_o <= 1'b0;
    else if (reject)  resend_req_o <= 1'b1;
    else if (sweep_i) resend_req_o <= 1'b0;
  end
endmodule

// File: rtl/intr_src_ctrl_chk.sv
module intr_src_ctrl_chk #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4,
  localparam int SW    = $clog2(NSRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sweep_i,
  input logic              dlv_vld_o,
  input logic [SW-1:0]     dlv_src_o,
  input logic [PRIO_W-1:0] dlv_prio_o,
  input logic [SRV_W-1:0]  dlv_server_o,
  input logic              rsp_vld_i,
  input logic              rsp_acc_i,
  input logic              resend_req_o
);
  // R10
  hold_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_vld_o && !rsp_vld_i |=> dlv_vld_o && $stable(dlv_src_o)
      && $stable(dlv_prio_o) && $stable(dlv_server_o));
  // R10
  drop_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_vld_o && rsp_vld_i |=> !dlv_vld_o);
  // R3
  no_masked_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_vld_o |-> dlv_prio_o != '1);
  // R6
  reject_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_vld_o && rsp_vld_i && !rsp_acc_i |=> resend_req_o);
  // R6
  sweep_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_i && !(dlv_vld_o && rsp_vld_i && !rsp_acc_i) |=> !resend_req_o);
endmodule

bind intr_src_ctrl intr_src_ctrl_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sweep_i      (sweep_i),
  .dlv_vld_o    (dlv_vld_o),
  .dlv_src_o    (dlv_src_o),
  .dlv_prio_o   (dlv_prio_o),
  .dlv_server_o (dlv_server_o),
  .rsp_vld_i    (rsp_vld_i),
  .rsp_acc_i    (rsp_acc_i),
  .resend_req_o (resend_req_o)
);

// File: tb/test_intr_src_ctrl.sv
module test_intr_src_ctrl;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  logic lvl_vld = 0, lvl_set = 0, cfg_vld = 0, eoi_vld = 0, bounce_vld = 0, sweep = 0;
  logic [3:0] lvl_src = 0, cfg_src = 0, eoi_src = 0, bounce_src = 0;
  logic [1:0] cfg_op = 0;
  logic [3:0] cfg_server = 0;
  logic [7:0] cfg_prio = 0;
  logic rsp_vld = 0, rsp_acc = 0;
  logic dlv_vld, resend_req;
  logic [3:0] dlv_src, dlv_server;
  logic [7:0] dlv_prio;

  int checks = 0, errors = 0;
  bit pres_acc = 1, pres_rand = 0;
  int lat_cnt = 0;
  int log_q[$];
  bit prev_vld = 0;

  always #5 clk = ~clk;

  intr_src_ctrl i_intr_src_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .lvl_vld_i(lvl_vld), .lvl_src_i(lvl_src), .lvl_set_i(lvl_set),
    .cfg_vld_i(cfg_vld), .cfg_op_i(cfg_op), .cfg_src_i(cfg_src),
    .cfg_server_i(cfg_server), .cfg_prio_i(cfg_prio),
    .eoi_vld_i(eoi_vld), .eoi_src_i(eoi_src),
    .bounce_vld_i(bounce_vld), .bounce_src_i(bounce_src),
    .sweep_i(sweep),
    .dlv_vld_o(dlv_vld), .dlv_src_o(dlv_src), .dlv_prio_o(dlv_prio),
    .dlv_server_o(dlv_server),
    .rsp_vld_i(rsp_vld), .rsp_acc_i(rsp_acc), .resend_req_o(resend_req)
  );

  // reference model
  int m_prio[N], m_saved[N], m_srv[N];
  bit m_asrt[N], m_rs[N], m_mp[N], m_want[N];
  bit m_busy, m_rreq;
  int m_src, m_pri, m_dsrv, m_ptr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 255; m_saved[i] = 255; m_srv[i] = 0;
        m_asrt[i] = 0; m_rs[i] = 0; m_mp[i] = 0; m_want[i] = 0;
      end
      m_busy = 0; m_rreq = 0; m_src = 0; m_pri = 0; m_dsrv = 0; m_ptr = 0;
    end else begin
      int pick;
      bit rej;
      pick = -1; rej = 0;
      if (!m_busy)
        for (int k = 0; k < N; k++)
          if (pick < 0 && m_want[(m_ptr + k) % N]) pick = (m_ptr + k) % N;
      if (pick >= 0) begin
        m_want[pick] = 0; m_rs[pick] = 0;
        if (m_prio[pick] == 255) m_mp[pick] = 1;
        else begin m_busy = 1; m_src = pick; m_pri = m_prio[pick]; m_dsrv = m_srv[pick]; end
        m_ptr = (pick + 1) % N;
      end else if (m_busy && rsp_vld) begin
        m_busy = 0;
        if (!rsp_acc) begin m_rs[m_src] = 1; rej = 1; end
      end
      if (lvl_vld) begin
        if (lvl_set) begin m_asrt[lvl_src] = 1; m_want[lvl_src] = 1; end
        else m_asrt[lvl_src] = 0;
      end
      if (cfg_vld) begin
        int s;
        s = cfg_src;
        if (cfg_op == 0) begin
          m_srv[s] = cfg_server; m_prio[s] = cfg_prio; m_saved[s] = cfg_prio;
          if ((m_mp[s] || m_rs[s]) && cfg_prio != 255) begin m_mp[s] = 0; m_want[s] = 1; end
        end else if (cfg_op == 1) begin
          m_saved[s] = m_prio[s]; m_prio[s] = 255;
        end else if (cfg_op == 2) begin
          m_prio[s] = m_saved[s];
          if ((m_mp[s] || m_rs[s]) && m_saved[s] != 255) begin m_mp[s] = 0; m_want[s] = 1; end
        end
      end
      if (eoi_vld && m_asrt[eoi_src]) m_want[eoi_src] = 1;
      if (bounce_vld) m_want[bounce_src] = 1;
      if (sweep) for (int i = 0; i < N; i++) if (m_rs[i]) m_want[i] = 1;
      if (rej) m_rreq = 1;
      else if (sweep) m_rreq = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, presenter, offer log
  always @(negedge clk) begin
    chk("R10 dlv_vld", dlv_vld, m_busy);
    if (m_busy) begin
      chk("R10 dlv_src", dlv_src, m_src);
      chk("R10 dlv_prio", dlv_prio, m_pri);
      chk("R10 dlv_server", dlv_server, m_dsrv);
    end
    chk("R6 resend_req", resend_req, m_rreq);
    if (dlv_vld && !prev_vld) log_q.push_back({dlv_src, dlv_prio, dlv_server});
    prev_vld = dlv_vld;
    if (dlv_vld && !rsp_vld) begin
      if (lat_cnt >= 2) begin
        rsp_vld = 1; rsp_acc = pres_rand ? 1'($urandom % 2) : pres_acc; lat_cnt = 0;
      end else lat_cnt++;
    end else rsp_vld = 0;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic ev_lvl(int s, bit set);
    lvl_vld = 1; lvl_src = 4'(s); lvl_set = set; @(negedge clk); lvl_vld = 0;
  endtask
  task automatic ev_cfg(int s, int op, int srv, int pr);
    cfg_vld = 1; cfg_src = 4'(s); cfg_op = 2'(op); cfg_server = 4'(srv); cfg_prio = 8'(pr);
    @(negedge clk); cfg_vld = 0;
  endtask
  task automatic ev_eoi(int s);
    eoi_vld = 1; eoi_src = 4'(s); @(negedge clk); eoi_vld = 0;
  endtask
  task automatic ev_bounce(int s);
    bounce_vld = 1; bounce_src = 4'(s); @(negedge clk); bounce_vld = 0;
  endtask
  task automatic ev_sweep();
    sweep = 1; @(negedge clk); sweep = 0;
  endtask
  task automatic chk_log(string tag, int n, int s, int pr, int srv);
    chk({tag, " offers"}, log_q.size(), n);
    if (n > 0 && log_q.size() > 0) chk({tag, " offer"}, log_q[0], (s << 12) | (pr << 4) | srv);
    log_q.delete();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1 idle vld", dlv_vld, 0);
    chk("R1 idle resend", resend_req, 0);
    // R1 R3: unconfigured source is masked
    ev_lvl(3, 1); idle(10);
    chk_log("R1", 0, 0, 0, 0);
    // R4: write replays masked-pending
    ev_cfg(3, 0, 5, 4); idle(10);
    chk_log("R4", 1, 3, 4, 5);
    ev_cfg(7, 0, 1, 2); idle(10);
    chk_log("R4 no flags", 0, 0, 0, 0);
    // R2
    ev_lvl(7, 1); idle(10);
    chk_log("R2 set", 1, 7, 2, 1);
    ev_lvl(7, 0); idle(10);
    chk_log("R2 clear", 0, 0, 0, 0);
    // R8
    ev_eoi(7); idle(10);
    chk_log("R8 not asserted", 0, 0, 0, 0);
    ev_eoi(3); idle(10);
    chk_log("R8 asserted", 1, 3, 4, 5);
    // R6 reject
    pres_acc = 0;
    ev_cfg(9, 0, 2, 6); ev_lvl(9, 1); idle(10);
    chk_log("R6 offer", 1, 9, 6, 2);
    chk("R6 req raised", resend_req, 1);
    // R7 sweep
    pres_acc = 1;
    ev_sweep(); idle(10);
    chk_log("R7", 1, 9, 6, 2);
    chk("R6 req cleared", resend_req, 0);
    // R5 off then on
    pres_acc = 0;
    ev_bounce(9); idle(10);
    log_q.delete();
    ev_cfg(9, 1, 0, 0);
    pres_acc = 1;
    ev_sweep(); idle(10);
    chk_log("R5 off", 0, 0, 0, 0);
    ev_cfg(9, 3, 0, 0); idle(10);
    chk_log("R5 op3", 0, 0, 0, 0);
    ev_cfg(9, 2, 0, 0); idle(10);
    chk_log("R5 on", 1, 9, 6, 2);
    // R9
    ev_bounce(3); idle(10);
    chk_log("R9", 1, 3, 4, 5);
    ev_bounce(12); idle(10);
    chk_log("R9 masked", 0, 0, 0, 0);
    // R10 round robin of two rejected sources
    ev_cfg(1, 0, 6, 3); ev_cfg(14, 0, 7, 5);
    pres_acc = 0;
    ev_bounce(14); ev_bounce(1); idle(20);
    log_q.delete();
    pres_acc = 1;
    ev_sweep(); idle(20);
    chk("R7 two offers", log_q.size(), 2);
    log_q.delete();
    // random phase, checked against the model every cycle
    pres_rand = 1;
    for (int c = 0; c < 4000; c++) begin
      lvl_vld = ($urandom % 4) == 0; lvl_src = 4'($urandom); lvl_set = 1'($urandom);
      cfg_vld = ($urandom % 5) == 0; cfg_src = 4'($urandom); cfg_op = 2'($urandom);
      cfg_server = 4'($urandom); cfg_prio = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 16);
      eoi_vld = ($urandom % 6) == 0; eoi_src = 4'($urandom);
      bounce_vld = ($urandom % 8) == 0; bounce_src = 4'($urandom);
      sweep = ($urandom % 10) == 0;
      @(negedge clk);
    end
    lvl_vld = 0; cfg_vld = 0; eoi_vld = 0; bounce_vld = 0; sweep = 0;
    idle(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule